// File: doc/BRIEF.md
# Branch Condition and Delay-Slot Controller

This block sits at the front of an integer pipeline and resolves control transfer for conditional relative branches and relative calls. Each issued instruction arrives with its own address (`pc`), the address of the following instruction (`npc`, the delay-slot address) and the four integer condition flags. The block classifies the instruction, tests the flags against the 4-bit condition field, forms the PC-relative target and produces the next PC/nPC pair. Every control transfer has exactly one delay slot. A one-cycle `annul_next` pulse tells the front end to squash the delay-slot instruction it has already fetched.

The annul bit (instruction bit 29) is not applied the same way in every case. A branch that falls through with the bit set skips its delay slot. An unconditional branch with the bit set skips the slot and goes straight to the target. Every other taken branch runs the delay slot first and then reaches the target. A call always runs its slot, and it requests a write of its own address into link register 15. Two saturating event counters record taken transfers and annulled slots. Results are registered and appear one clock after the instruction is presented.

Top module: `bcu_branch_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `taken`, `annul_next` and `link_we` are 0, and `next_pc`, `next_npc`, `target`, `link_data` and both counters are 0.
- R2: For a branch (bits 31:30 = 00, bits 24:22 = 010), condition field bits 28:25 with codes 0..7 give taken = never, Z, Z|(N^V), N^V, C|Z, C, N, V respectively, where `flags` = {N, Z, V, C} (bit 3 = N, bit 0 = C).
- R3: Condition codes 8..15 give the logical negation of codes 0..7 in the same order; code 8 is always taken.
- R4: The branch target is `pc` plus bits 21:0 sign-extended from bit 21 and multiplied by 4, in 32-bit wrapping arithmetic.
- R5: A taken branch that is not (code 8 with bit 29 set) gives `next_pc` = `npc`, `next_npc` = target, `taken` = 1 and `annul_next` = 0, whatever bit 29 holds.
- R6: A branch that is not taken, with bit 29 clear, gives `next_pc` = `npc`, `next_npc` = `npc`+4, `taken` = 0 and `annul_next` = 0.
- R7: A branch that is not taken, with bit 29 set, gives `annul_next` = 1, `taken` = 0, `next_pc` = `npc`+4 and `next_npc` = `npc`+8.
- R8: Code 8 with bit 29 set gives `taken` = 1, `annul_next` = 1, `next_pc` = target and `next_npc` = target+4.
- R9: An instruction with bits 31:30 = 01 is a call. Its target is `pc` + 4 × bits 29:0 (wrapping). It gives `taken` = 1, `annul_next` = 0, `next_pc` = `npc`, `next_npc` = target, `link_we` = 1, `link_idx` = 15 and `link_data` = `pc`.
- R10: Any other instruction (bits 31:30 = 10 or 11, or 00 with bits 24:22 other than 010) gives `taken` = 0, `annul_next` = 0, `link_we` = 0, `next_pc` = `npc`, `next_npc` = `npc`+4, and leaves the counters unchanged.
- R11: `taken_cnt` adds one for each issued taken branch or call. `annul_cnt` adds one for each issued annulled slot. Each counter saturates at 2^CNT_W−1 and is cleared by reset.
- R12: Results appear on the outputs one clock after `in_valid` is sampled high. A cycle with `in_valid` low gives `out_valid`, `taken`, `annul_next` and `link_we` = 0 at the next clock, leaves `next_pc` and `next_npc` unchanged and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| npc | input | 32 | Address of the following (delay-slot) instruction |
| flags | input | 4 | Condition flags {N, Z, V, C} |
| out_valid | output | 1 | Registered result is for an issued instruction |
| taken | output | 1 | Control transfer taken |
| target | output | 32 | Branch or call target |
| next_pc | output | 32 | Next program counter |
| next_npc | output | 32 | Following program counter |
| annul_next | output | 1 | Squash the already-fetched delay-slot instruction |
| link_we | output | 1 | Write `link_data` into register `link_idx` |
| link_idx | output | 5 | Link register index (15) |
| link_data | output | 32 | Call address to be linked |
| taken_cnt | output | CNT_W | Saturating count of taken transfers |
| annul_cnt | output | CNT_W | Saturating count of annulled slots |

## Verification
An unconditional branch with its annul bit set is both a taken transfer and an annulled slot. In that single cycle it therefore increments `taken_cnt` and `annul_cnt` and redirects the PC pair to the target. The bench issues long runs of such branches, with a counter width reduced to four bits, so that both counters reach their ceiling together. Its scoreboard predicts each counter on its own and checks that neither wraps and neither misses a step. A conditional branch taken with the annul bit set is mixed in, and it must raise only the taken count.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned INSN_BYTES  = 4;
  localparam int unsigned DISP22_W    = 22;
  localparam int unsigned DISP30_W    = 30;
  localparam logic [1:0]  OP_FMT0     = 2'b00;
  localparam logic [1:0]  OP_CALL     = 2'b01;
  localparam logic [2:0]  SUB_BRANCH  = 3'b010;
  localparam logic [3:0]  CODE_ALWAYS = 4'h8;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  typedef enum logic [1:0] {
    KIND_SEQ    = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_CALL   = 2'd2
  } xfer_kind_t;

  // base test for the lower half of the condition space
  function automatic logic cond_base(input logic [2:0] sel, input cc_flags_t f);
    logic r;
    unique case (sel)
      3'd0: r = 1'b0;
      3'd1: r = f.z;
      3'd2: r = f.z | (f.n ^ f.v);
      3'd3: r = f.n ^ f.v;
      3'd4: r = f.c | f.z;
      3'd5: r = f.c;
      3'd6: r = f.n;
      default: r = f.v;
    endcase
    return r;
  endfunction

  // upper half is the inverse of the lower half
  function automatic logic cond_eval(input logic [3:0] code, input cc_flags_t f);
    return code[3] ^ cond_base(code[2:0], f);
  endfunction

  function automatic logic [WORD_W-1:0] rel_target22(input logic [WORD_W-1:0] base,
                                                     input logic [DISP22_W-1:0] disp);
    logic [WORD_W-1:0] sx;
    sx = {{(WORD_W-DISP22_W){disp[DISP22_W-1]}}, disp};
    return base + (sx << 2);
  endfunction

  function automatic logic [WORD_W-1:0] rel_target30(input logic [WORD_W-1:0] base,
                                                     input logic [DISP30_W-1:0] disp);
    return base + {disp, 2'b00};
  endfunction

  function automatic xfer_kind_t classify(input logic [WORD_W-1:0] ins);
    xfer_kind_t k;
    if (ins[31:30] == OP_CALL)
      k = KIND_CALL;
    else if (ins[31:30] == OP_FMT0 && ins[24:22] == SUB_BRANCH)
      k = KIND_BRANCH;
    else
      k = KIND_SEQ;
    return k;
  endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output xfer_kind_t        kind,
  output logic [3:0]        cond_code,
  output logic              annul_bit,
  output logic              is_always
);

  always_comb begin
    kind      = classify(instr);
    cond_code = instr[28:25];
    annul_bit = instr[29];
    is_always = (instr[28:25] == CODE_ALWAYS);
  end

endmodule

// File: rtl/bcu_cond.sv
module bcu_cond
  import bcu_pkg::*;
(
  input  logic [3:0] cond_code,
  input  cc_flags_t  flags,
  output logic       cond_true
);

  always_comb cond_true = cond_eval(cond_code, flags);

endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  input  xfer_kind_t        kind,
  output logic [WORD_W-1:0] target
);

  logic [WORD_W-1:0] br_tgt;
  logic [WORD_W-1:0] call_tgt;

  always_comb begin
    br_tgt   = rel_target22(pc, instr[DISP22_W-1:0]);
    call_tgt = rel_target30(pc, instr[DISP30_W-1:0]);
    target   = (kind == KIND_CALL) ? call_tgt : br_tgt;
  end

endmodule

// File: rtl/bcu_seq.sv
module bcu_seq
  import bcu_pkg::*;
(
  input  xfer_kind_t        kind,
  input  logic              cond_true,
  input  logic              annul_bit,
  input  logic              is_always,
  input  logic [WORD_W-1:0] npc,
  input  logic [WORD_W-1:0] target,
  output logic [WORD_W-1:0] nxt_pc,
  output logic [WORD_W-1:0] nxt_npc,
  output logic              xfer_taken,
  output logic              slot_annul,
  output logic              link_req
);

  localparam logic [WORD_W-1:0] STEP1 = WORD_W'(INSN_BYTES);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2 * INSN_BYTES);

  always_comb begin
    nxt_pc     = npc;
    nxt_npc    = npc + STEP1;
    xfer_taken = 1'b0;
    slot_annul = 1'b0;
    link_req   = 1'b0;
    unique case (kind)
      KIND_CALL: begin
        xfer_taken = 1'b1;
        link_req   = 1'b1;
        nxt_npc    = target;
      end
      KIND_BRANCH: begin
        if (cond_true) begin
          xfer_taken = 1'b1;
          if (is_always && annul_bit) begin
            slot_annul = 1'b1;
            nxt_pc     = target;
            nxt_npc    = target + STEP1;
          end else begin
            nxt_npc    = target;
          end
        end else if (annul_bit) begin
          slot_annul = 1'b1;
          nxt_pc     = npc + STEP1;
          nxt_npc    = npc + STEP2;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bcu_sat_cnt.sv
module bcu_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic at_max;
  assign at_max = (cnt == MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (inc && !at_max)
      cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != MAX) |=> (cnt == W'($past(cnt) + 1'b1))); // R11
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX) |=> (cnt == MAX)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R11

endmodule

// File: rtl/bcu_branch_ctl.sv
module bcu_branch_ctl
  import bcu_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_REG  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          instr,
  input  logic [31:0]          pc,
  input  logic [31:0]          npc,
  input  logic [3:0]           flags,
  output logic                 out_valid,
  output logic                 taken,
  output logic [31:0]          target,
  output logic [31:0]          next_pc,
  output logic [31:0]          next_npc,
  output logic                 annul_next,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [31:0]          link_data,
  output logic [CNT_W-1:0]     taken_cnt,
  output logic [CNT_W-1:0]     annul_cnt
);

  localparam int unsigned N_CNT = 2;
  localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

  // internal events brought out as named wires
  xfer_kind_t        d_kind;
  logic [3:0]        d_code;
  logic              d_annul_bit;
  logic              d_always;
  logic              c_true;
  logic [WORD_W-1:0] t_target;
  logic [WORD_W-1:0] s_pc;
  logic [WORD_W-1:0] s_npc;
  logic              s_taken;
  logic              s_annul;
  logic              s_link;
  logic              ev_taken;
  logic              ev_annul;

  bcu_decode u_decode (
    .instr     (instr),
    .kind      (d_kind),
    .cond_code (d_code),
    .annul_bit (d_annul_bit),
    .is_always (d_always)
  );

  bcu_cond u_cond (
    .cond_code (d_code),
    .flags     (cc_flags_t'(flags)),
    .cond_true (c_true)
  );

  bcu_target u_target (
    .instr  (instr),
    .pc     (pc),
    .kind   (d_kind),
    .target (t_target)
  );

  bcu_seq u_seq (
    .kind       (d_kind),
    .cond_true  (c_true),
    .annul_bit  (d_annul_bit),
    .is_always  (d_always),
    .npc        (npc),
    .target     (t_target),
    .nxt_pc     (s_pc),
    .nxt_npc    (s_npc),
    .xfer_taken (s_taken),
    .slot_annul (s_annul),
    .link_req   (s_link)
  );

  assign ev_taken = in_valid & s_taken;
  assign ev_annul = in_valid & s_annul;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      annul_next <= 1'b0;
      link_we    <= 1'b0;
      target     <= '0;
      next_pc    <= '0;
      next_npc   <= '0;
      link_data  <= '0;
    end else begin
      out_valid  <= in_valid;
      taken      <= ev_taken;
      annul_next <= ev_annul;
      link_we    <= in_valid & s_link;
      if (in_valid) begin
        target   <= t_target;
        next_pc  <= s_pc;
        next_npc <= s_npc;
        if (s_link)
          link_data <= pc;
      end
    end
  end

  assign link_idx = LINK_IDX;

  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  assign cnt_inc = {ev_annul, ev_taken};

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    bcu_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[gi]),
      .cnt   (cnt_val[gi])
    );
  end

  assign taken_cnt = cnt_val[0];
  assign annul_cnt = cnt_val[1];

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (taken || annul_next || link_we) |-> out_valid); // R12
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(next_npc))); // R12
  AST_LINK_NO_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (!annul_next && taken && link_idx == LINK_IDX)); // R9
  AST_TAKEN_SLOT_THEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !annul_next) |-> (next_npc == target)); // R5
  AST_ALWAYS_ANNUL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && annul_next) |-> (next_pc == target)); // R8
  AST_SKIP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (annul_next && !taken) |-> (next_npc == next_pc + 32'd4)); // R7
  AST_SEQ_NO_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && d_kind == KIND_SEQ) |=> (!taken && !annul_next && !link_we)); // R10

endmodule

// File: tb/bcu_branch_ctl_test.sv
`timescale 1ns/1ps
module bcu_branch_ctl_test;

  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [31:0] npc = '0;
  logic [3:0]  flags = '0;
  logic        out_valid, taken, annul_next, link_we;
  logic [31:0] target, next_pc, next_npc, link_data;
  logic [4:0]  link_idx;
  logic [CW-1:0] taken_cnt, annul_cnt;

  always #10 clk = ~clk;

  bcu_branch_ctl #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .npc(npc), .flags(flags), .out_valid(out_valid), .taken(taken),
    .target(target), .next_pc(next_pc), .next_npc(next_npc),
    .annul_next(annul_next), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .taken_cnt(taken_cnt), .annul_cnt(annul_cnt)
  );

  typedef struct {
    bit          valid, tk, an, lk, chk_tgt;
    logic [31:0] npc_o, nnpc_o, tgt, ldata;
    int          tc, ac;
    string       req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int m_tc = 0;
  int m_ac = 0;
  logic [31:0] m_last_pc = '0;
  logic [31:0] m_last_npc = '0;
  bit stim_done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_cond(input int code, input logic [3:0] f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (code)
      0: return 0;            1: return z;
      2: return z | (n ^ v);  3: return n ^ v;
      4: return c | z;        5: return c;
      6: return n;            7: return v;
      8: return 1;            9: return !z;
      10: return !(z | (n ^ v)); 11: return !(n ^ v);
      12: return !(c | z);    13: return !c;
      14: return !n;          default: return !v;
    endcase
  endfunction

  function automatic logic [31:0] mk_bra(input bit an, input int code, input logic [21:0] d);
    return {2'b00, an, 4'(code), 3'b010, d};
  endfunction

  task automatic issue(input bit v, input logic [31:0] ins, input logic [31:0] p,
                       input logic [31:0] np, input logic [3:0] f, input string req);
    exp_t e;
    int code;
    logic [31:0] tg;
    @(negedge clk);
    in_valid = v; instr = ins; pc = p; npc = np; flags = f;
    e.valid = v; e.tk = 0; e.an = 0; e.lk = 0; e.chk_tgt = 0;
    e.tgt = '0; e.ldata = '0; e.req = req;
    e.npc_o = np; e.nnpc_o = np + 32'd4;
    if (!v) begin
      e.npc_o = m_last_pc; e.nnpc_o = m_last_npc;
    end else if (ins[31:30] == 2'b01) begin
      tg = p + ins[29:0] * 32'd4;
      e.tk = 1; e.lk = 1; e.ldata = p; e.tgt = tg; e.chk_tgt = 1;
      e.nnpc_o = tg;
    end else if (ins[31:30] == 2'b00 && ins[24:22] == 3'b010) begin
      code = int'(ins[28:25]);
      tg = p + 32'(signed'(ins[21:0])) * 32'd4;
      e.tgt = tg; e.chk_tgt = 1;
      if (m_cond(code, f)) begin
        e.tk = 1;
        if (code == 8 && ins[29]) begin
          e.an = 1; e.npc_o = tg; e.nnpc_o = tg + 32'd4;
        end else e.nnpc_o = tg;
      end else if (ins[29]) begin
        e.an = 1; e.npc_o = np + 32'd4; e.nnpc_o = np + 32'd8;
      end
    end
    if (e.tk && m_tc < CMAX) m_tc++;
    if (e.an && m_ac < CMAX) m_ac++;
    e.tc = m_tc; e.ac = m_ac;
    m_last_pc = e.npc_o; m_last_npc = e.nnpc_o;
    q.push_back(e);
  endtask

  // monitor: result of inputs clocked at this edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({out_valid, taken, annul_next, link_we} == {e.valid, e.tk, e.an, e.lk},
              e.valid ? e.req : "R12", {60'd0, out_valid, taken, annul_next, link_we},
              {60'd0, e.valid, e.tk, e.an, e.lk});
        check(next_pc == e.npc_o && next_npc == e.nnpc_o, e.valid ? e.req : "R12",
              {next_pc, next_npc}, {e.npc_o, e.nnpc_o});
        if (e.valid && e.chk_tgt)
          check(target == e.tgt, "R4", {32'd0, target}, {32'd0, e.tgt});
        if (e.lk)
          check(link_data == e.ldata && link_idx == 5'd15, "R9",
                {27'd0, link_idx, link_data}, {27'd0, 5'd15, e.ldata});
        check(int'(taken_cnt) == e.tc && int'(annul_cnt) == e.ac, "R11",
              {32'(taken_cnt), 32'(annul_cnt)}, {32'(e.tc), 32'(e.ac)});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [3:0] FPAT [6] = '{4'b0000, 4'b1111, 4'b0101, 4'b1010, 4'b1000, 4'b0010};

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({out_valid, taken, annul_next, link_we} == 4'b0 && next_pc == 0 && next_npc == 0
          && target == 0 && link_data == 0 && taken_cnt == 0 && annul_cnt == 0, "R1",
          {next_pc, 24'd0, taken_cnt, annul_cnt}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(out_valid == 0 && taken_cnt == 0 && annul_cnt == 0, "R1",
          {63'd0, out_valid}, 64'd0);

    // condition sweep, annul clear: R2 low codes, R3 negated codes
    for (int code = 0; code < 16; code++)
      for (int fi = 0; fi < 6; fi++)
        issue(1, mk_bra(0, code, 22'h40 + 22'(code)), 32'h1000 + 32'(code * 64),
              32'h1004 + 32'(code * 64), FPAT[fi], code < 8 ? "R2" : "R3");

    // targets: negative displacement and wrap (R4)
    issue(1, mk_bra(0, 8, 22'h3FFFFC), 32'h0000_2000, 32'h0000_2004, 4'b0, "R4");
    issue(1, mk_bra(0, 8, 22'h200000), 32'h0080_0000, 32'h0080_0004, 4'b0, "R4");
    issue(1, mk_bra(0, 8, 22'h000010), 32'hFFFF_FFF0, 32'hFFFF_FFF4, 4'b0, "R4");

    // taken conditional with annul still runs the slot (R5)
    issue(1, mk_bra(1, 1, 22'h20), 32'h3000, 32'h3004, 4'b0100, "R5");
    issue(1, mk_bra(1, 9, 22'h3FFFF0), 32'h3100, 32'h3104, 4'b0000, "R5");
    // not taken, annul clear (R6) and set (R7)
    issue(1, mk_bra(0, 1, 22'h20), 32'h3200, 32'h3204, 4'b0000, "R6");
    issue(1, mk_bra(1, 1, 22'h20), 32'h3300, 32'h3304, 4'b0000, "R7");
    issue(1, mk_bra(1, 0, 22'h20), 32'h3400, 32'h3404, 4'b1111, "R7");
    // always with annul jumps straight to target (R8)
    issue(1, mk_bra(1, 8, 22'h100), 32'h3500, 32'h3504, 4'b0000, "R8");

    // calls: bit 29 set in displacement, wrap (R9)
    issue(1, {2'b01, 30'h0000_0040}, 32'h4000, 32'h4004, 4'b0, "R9");
    issue(1, {2'b01, 30'h3FFF_FFF0}, 32'h4100, 32'h4104, 4'b1111, "R9");

    // non-control words (R10)
    issue(1, {2'b10, 1'b1, 4'h8, 25'h0ABCDE}, 32'h5000, 32'h5004, 4'b1111, "R10");
    issue(1, {2'b11, 1'b1, 4'h8, 3'b010, 22'h10}, 32'h5100, 32'h5104, 4'b0, "R10");
    issue(1, {2'b00, 1'b1, 4'h8, 3'b100, 22'h10}, 32'h5200, 32'h5204, 4'b0, "R10");
    issue(1, {2'b00, 1'b1, 4'h8, 3'b110, 22'h10}, 32'h5300, 32'h5304, 4'b0, "R10");

    // idle cycles: a valid-looking call word presented with in_valid low (R12)
    issue(0, {2'b01, 30'h10}, 32'h6000, 32'h6004, 4'b0, "R12");
    issue(0, mk_bra(1, 8, 22'h10), 32'h6100, 32'h6104, 4'b0, "R12");

    // both counters move in the same cycle and saturate together (R11)
    for (int i = 0; i < 20; i++)
      issue(1, mk_bra(1, 8, 22'(i + 1)), 32'h7000 + 32'(i * 8), 32'h7004 + 32'(i * 8), 4'b0, "R11");
    issue(1, mk_bra(1, 1, 22'h8), 32'h7800, 32'h7804, 4'b0100, "R11");
    issue(0, '0, '0, '0, 4'b0, "R12");

    // reset clears counters again (R1)
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #2;
    check(taken_cnt == 0 && annul_cnt == 0 && out_valid == 0, "R1",
          {32'(taken_cnt), 32'(annul_cnt)}, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule